// File: doc/BRIEF.md
# I2S Slave Audio Port

This block is a serial audio port for a codec or amplifier that owns the clocks. The external device drives both the word-select (frame) clock and the bit clock. The port never generates either clock. The port shifts stereo playback samples out on one serial line and shifts microphone samples in on another. On the system side, each direction is a plain valid/ready word interface in the system clock domain.

The two serial clocks and the serial input pass through two-flop synchronizers. Their edges are then detected in the system clock. Each change of the word-select line starts a new slot: low selects left and high selects right. A bit index counts falling bit-clock edges from the start of the slot.

A ten-bit control word sets two fields, and the sample's bits are placed in the slot according to them:
- **Delay field:** the number of bit periods between the word-select edge and the first data bit.
- **Width field:** the sample width.

Playback words are taken at each slot start. If no playback word is offered at that moment, the slot carries silence and the port flags an underrun. Captured words are delivered right-justified, with a tag that gives their slot. A monaural microphone therefore yields the same value twice per frame.

Top module: `i2s_slave_port`

## Requirements
- R1: The port only ever drives the serial data output. That output changes only after a falling edge of the incoming bit clock, and it holds through the following rising edge.
- R2: With delay field D, the first data bit of a slot occupies bit position D after the word-select change, where position 0 is the bit launched on the same falling edge as that change. Every position before the first data bit carries 0 on the output and is ignored on the input.
- R3: After reset the control word is delay 1 and width code 0. The port therefore uses one-bit-late alignment with 32-bit samples before any control write.
- R4: Width code 0 means a 32-bit sample, and codes 1 to 15 mean that many bits. Positions after the last sample bit carry 0 on the output and are ignored on the input.
- R5: Every width code from 16 to 31 behaves exactly like a 16-bit sample.
- R6: Samples are sent most-significant bit first. A transmitted sample is the low W bits of the 32-bit playback word, and bit W-1 is sent first.
- R7: At each slot start the port asserts `tx_ready` for one cycle and takes at most one playback word. Slots alternate left (word-select low) and right (word-select high) in the order the external device sets.
- R8: If `tx_valid` is low when a slot starts, the slot transmits all zeros and `tx_underrun` pulses high for exactly one cycle.
- R9: Input bits are sampled on the rising bit-clock edge, MSB first. The W captured bits are delivered zero-extended in `rx_data`, with `rx_right` set to the word-select level of their slot. Both slots of a frame are delivered, so a monaural source shows the same value twice.
- R10: `rx_valid` stays high, and `rx_data` stays stable, until `rx_ready` accepts the word. A word completed before acceptance replaces the pending one.
- R11: A cycle with `cfg_we` high loads `cfg_wdata`, with the delay in bits [4:0] and the width code in bits [9:5]. Otherwise the control word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word: [9:5] width code, [4:0] delay |
| sck_i | input | 1 | Bit clock from the external device |
| ws_i | input | 1 | Word-select clock from the external device |
| sd_i | input | 1 | Serial capture data |
| sd_o | output | 1 | Serial playback data |
| tx_data | input | 32 | Playback word, sample in the low W bits |
| tx_valid | input | 1 | Playback word offered |
| tx_ready | output | 1 | Playback word taken this cycle |
| tx_underrun | output | 1 | One-cycle pulse: slot started with no playback word |
| rx_data | output | 32 | Captured sample, right-justified |
| rx_right | output | 1 | Captured sample belongs to the right slot |
| rx_valid | output | 1 | Captured word pending |
| rx_ready | input | 1 | Captured word accepted |

## Verification
A wrong slot bit index or wrong width decode shows up within the same slot. The serial output then carries a shifted or truncated bit image, and the captured word differs in value or arrives early or late, both by the end of that slot. A word-select edge that is lost or invented swaps or duplicates a playback word and changes the handshake count in the next slot. A stuck capture output register shows up as a missing or stale word when the next slot completes.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

    localparam int FIELD_W = 5;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(2 * WORD_W);

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Control word: width code in the upper field, delay in the lower field.
    typedef struct packed {
        field_t width_code;
        field_t delay;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{width_code: field_t'(0), delay: field_t'(1)};

    // Position of a slot bit relative to the sample window.
    typedef struct packed {
        logic hit;
        idx_t off;
        idx_t last;
    } win_t;

    // Decode of the width code: zero selects a full word, large codes clamp to 16.
    function automatic idx_t eff_width(field_t code);
        if (code == '0) begin
            return idx_t'(WORD_W);
        end else if (code >= field_t'(16)) begin
            return idx_t'(16);
        end else begin
            return idx_t'(code);
        end
    endfunction

    function automatic win_t locate(idx_t idx, field_t delay, field_t code);
        win_t w;
        idx_t we;
        we     = eff_width(code);
        w.off  = idx - idx_t'(delay);
        w.hit  = (idx >= idx_t'(delay)) && (w.off < we);
        w.last = we - idx_t'(1);
        return w;
    endfunction

endpackage

// File: rtl/i2s_edge_sync.sv
module i2s_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int LINES = 3;
    localparam int L_SCK = 0;
    localparam int L_WS  = 1;
    localparam int L_SD  = 2;

    typedef struct packed {
        logic [STAGES-1:0][LINES-1:0] chain;
        logic                         sck_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic [LINES-1:0] raw;
    logic             sck_s;

    assign raw = {sd_i, ws_i, sck_i};

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.sck_prev = sync_q.chain[STAGES-1][L_SCK];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sck_s      = sync_q.chain[STAGES-1][L_SCK];
    assign sck_rise_o = sck_s & ~sync_q.sck_prev;
    assign sck_fall_o = ~sck_s & sync_q.sck_prev;
    assign ws_o       = sync_q.chain[STAGES-1][L_WS];
    assign sd_o       = sync_q.chain[STAGES-1][L_SD];

    // R1: a detected falling edge cannot repeat on the next cycle
    a_r1_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        sck_fall_o |=> !sck_fall_o);

endmodule

// File: rtl/i2s_slot_timer.sv
module i2s_slot_timer
    import i2s_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_rise_i,
    input  logic sck_fall_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic fall_o,
    output logic rise_o,
    output logic start_o,
    output logic right_o,
    output idx_t idx_o,
    output logic sd_o
);
    typedef struct packed {
        logic primed;
        logic ws_prev;
        logic right;
        idx_t idx;
        logic fall;
        logic rise;
        logic start;
        logic sd;
    } tmr_t;

    localparam tmr_t TMR_RESET = '{primed: 1'b0, ws_prev: 1'b0, right: 1'b0,
                                   idx: '1, fall: 1'b0, rise: 1'b0,
                                   start: 1'b0, sd: 1'b0};

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.fall  = sck_fall_i;
        tmr_d.rise  = sck_rise_i;
        tmr_d.start = 1'b0;
        if (sck_rise_i) begin
            tmr_d.sd = sd_i;
        end
        if (sck_fall_i) begin
            if (!tmr_q.primed) begin
                tmr_d.primed  = 1'b1;
                tmr_d.ws_prev = ws_i;
            end else if (ws_i != tmr_q.ws_prev) begin
                tmr_d.start   = 1'b1;
                tmr_d.idx     = '0;
                tmr_d.right   = ws_i;
                tmr_d.ws_prev = ws_i;
            end else if (tmr_q.idx != '1) begin
                tmr_d.idx = tmr_q.idx + idx_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= TMR_RESET;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign fall_o  = tmr_q.fall;
    assign rise_o  = tmr_q.rise;
    assign start_o = tmr_q.start;
    assign right_o = tmr_q.right;
    assign idx_o   = tmr_q.idx;
    assign sd_o    = tmr_q.sd;

    // R7: a slot starts only on a bit-clock falling edge
    a_r7_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> fall_o);

    // R1: rising and falling events never coincide
    a_r1_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !rise_o);

    // R2: the bit index only moves on a falling edge
    a_r2_idx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall_i |=> $stable(idx_o));

endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
    import i2s_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fall_i,
    input  logic   start_i,
    input  idx_t   idx_i,
    input  field_t delay_i,
    input  field_t width_i,
    input  word_t  tx_data_i,
    input  logic   tx_valid_i,
    output logic   tx_ready_o,
    output logic   underrun_o,
    output logic   sd_o
);
    typedef struct packed {
        word_t word;
        logic  sd;
        logic  underrun;
    } txl_t;

    txl_t  txl_d, txl_q;
    word_t word_sel;
    win_t  win;
    idx_t  sel;

    assign tx_ready_o = start_i;

    always_comb begin
        txl_d          = txl_q;
        txl_d.underrun = 1'b0;
        word_sel       = txl_q.word;
        if (start_i) begin
            if (tx_valid_i) begin
                word_sel = tx_data_i;
            end else begin
                word_sel       = '0;
                txl_d.underrun = 1'b1;
            end
            txl_d.word = word_sel;
        end
        win = locate(idx_i, delay_i, width_i);
        sel = win.last - win.off;
        if (fall_i) begin
            txl_d.sd = win.hit && (|(word_sel & (word_t'(1) << sel)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txl_q <= '0;
        end else begin
            txl_q <= txl_d;
        end
    end

    assign sd_o       = txl_q.sd;
    assign underrun_o = txl_q.underrun;

    // R1: the serial output moves only after a falling edge
    a_r1_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(sd_o));

    // R8: an underrun follows a slot start that found no word
    a_r8_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> $past(start_i && !tx_valid_i));

    // R8: the underrun flag is a single-cycle pulse
    a_r8_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);

endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
    import i2s_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise_i,
    input  logic   sd_i,
    input  idx_t   idx_i,
    input  logic   right_i,
    input  field_t delay_i,
    input  field_t width_i,
    input  logic   rx_ready_i,
    output logic   rx_valid_o,
    output word_t  rx_data_o,
    output logic   rx_right_o
);
    typedef struct packed {
        word_t shift;
        word_t data;
        logic  valid;
        logic  right;
    } rxl_t;

    rxl_t  rxl_d, rxl_q;
    win_t  win;
    word_t sh;

    always_comb begin
        rxl_d = rxl_q;
        win   = locate(idx_i, delay_i, width_i);
        sh    = (win.off == '0) ? word_t'(sd_i) : ((rxl_q.shift << 1) | word_t'(sd_i));
        if (rxl_q.valid && rx_ready_i) begin
            rxl_d.valid = 1'b0;
        end
        if (rise_i && win.hit) begin
            rxl_d.shift = sh;
            if (win.off == win.last) begin
                rxl_d.data  = sh;
                rxl_d.valid = 1'b1;
                rxl_d.right = right_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxl_q <= '0;
        end else begin
            rxl_q <= rxl_d;
        end
    end

    assign rx_valid_o = rxl_q.valid;
    assign rx_data_o  = rxl_q.data;
    assign rx_right_o = rxl_q.right;

    // R10: a pending word is held until accepted
    a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o && !rx_ready_i |=> rx_valid_o);

    // R10: pending data does not move without a new capture
    a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o && !rx_ready_i && !rise_i |=> $stable(rx_data_o));

    // R9: a word appears only after a rising-edge sample
    a_r9_word_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid_o) |-> $past(rise_i));

endmodule

// File: rtl/i2s_slave_port.sv
module i2s_slave_port
    import i2s_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [9:0]  cfg_wdata,
    input  logic        sck_i,
    input  logic        ws_i,
    input  logic        sd_i,
    output logic        sd_o,
    input  logic [31:0] tx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        tx_underrun,
    output logic [31:0] rx_data,
    output logic        rx_right,
    output logic        rx_valid,
    input  logic        rx_ready
);
    cfg_t cfg_d, cfg_q;

    logic sck_rise, sck_fall, ws_s, sd_s;
    logic t_fall, t_rise, t_start, t_right, t_sd;
    idx_t t_idx;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = cfg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    i2s_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .ws_i       (ws_i),
        .sd_i       (sd_i),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .ws_o       (ws_s),
        .sd_o       (sd_s)
    );

    i2s_slot_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .ws_i       (ws_s),
        .sd_i       (sd_s),
        .fall_o     (t_fall),
        .rise_o     (t_rise),
        .start_o    (t_start),
        .right_o    (t_right),
        .idx_o      (t_idx),
        .sd_o       (t_sd)
    );

    i2s_tx_lane u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (t_fall),
        .start_i    (t_start),
        .idx_i      (t_idx),
        .delay_i    (cfg_q.delay),
        .width_i    (cfg_q.width_code),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .underrun_o (tx_underrun),
        .sd_o       (sd_o)
    );

    i2s_rx_lane u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (t_rise),
        .sd_i       (t_sd),
        .idx_i      (t_idx),
        .right_i    (t_right),
        .delay_i    (cfg_q.delay),
        .width_i    (cfg_q.width_code),
        .rx_ready_i (rx_ready),
        .rx_valid_o (rx_valid),
        .rx_data_o  (rx_data),
        .rx_right_o (rx_right)
    );

    // R11: the control word changes only through a write
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    // R7: the handshake pulse lasts one cycle
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

endmodule

// File: tb/i2s_slave_port_bench.sv
module i2s_slave_port_bench;

    localparam int HP        = 8;
    localparam int SLOT_BITS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic        sck_i = 1'b1;
    logic        ws_i = 1'b1;
    logic        sd_i = 1'b1;
    logic        sd_o;
    logic [31:0] tx_data;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_underrun;
    logic [31:0] rx_data;
    logic        rx_right;
    logic        rx_valid;
    logic        rx_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int kprov  = 0;
    int kexp   = 0;
    bit adv    = 1'b0;
    int hs_cnt = 0;
    int ur_cnt = 0;
    int rx_cnt = 0;
    int rx_seen = 0;
    logic [31:0] rx_last = '0;
    logic        rx_last_right = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(int k);
        return 32'h5A3C_96E1 ^ (32'h9E37_79B9 * k) ^ {k[15:0], k[15:0]};
    endfunction

    function automatic int eff_w(int code);
        if (code == 0) return 32;
        if (code >= 16) return 16;
        return code;
    endfunction

    function automatic logic [31:0] wmask(int we);
        if (we == 32) return '1;
        return (32'd1 << we) - 32'd1;
    endfunction

    assign tx_data = pat(kprov);

    i2s_slave_port u_i2s_slave_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .sck_i       (sck_i),
        .ws_i        (ws_i),
        .sd_i        (sd_i),
        .sd_o        (sd_o),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_underrun (tx_underrun),
        .rx_data     (rx_data),
        .rx_right    (rx_right),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready)
    );

    always @(negedge clk) begin
        if (adv) begin
            kprov = kprov + 1;
            adv   = 1'b0;
        end
        if (tx_ready && tx_valid) begin
            adv    = 1'b1;
            hs_cnt = hs_cnt + 1;
        end
        if (tx_underrun) ur_cnt = ur_cnt + 1;
        if (rx_valid && rx_ready) begin
            rx_cnt        = rx_cnt + 1;
            rx_last       = rx_data;
            rx_last_right = rx_right;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_bit(input logic ws_v, input logic sd_v, output logic s_lo, output logic s_hi);
        @(negedge clk);
        sck_i = 1'b0;
        ws_i  = ws_v;
        sd_i  = sd_v;
        repeat (HP - 1) @(negedge clk);
        s_lo = sd_o;
        @(negedge clk);
        sck_i = 1'b1;
        repeat (HP - 1) @(negedge clk);
        s_hi = sd_o;
    endtask

    task automatic write_cfg(input int d, input int code);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {code[4:0], d[4:0]};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic preroll();
        logic lo, hi;
        for (int i = 0; i < 2; i++) do_bit(1'b1, 1'b1, lo, hi);
    endtask

    task automatic run_slot(input bit right, input int d, input int code, input bit tx_on,
                            input logic [31:0] mic, input bit chk_rx, input string req);
        int we;
        int hs0;
        int ur0;
        logic [31:0] word;
        logic [SLOT_BITS-1:0] got, expv;
        int instab;
        logic lo, hi, eb, mb;
        we     = eff_w(code);
        word   = tx_on ? pat(kexp) : 32'd0;
        if (tx_on) kexp++;
        hs0    = hs_cnt;
        ur0    = ur_cnt;
        instab = 0;
        tx_valid = tx_on;
        for (int j = 0; j < SLOT_BITS; j++) begin
            int b;
            b  = j - d;
            eb = (j >= d && b < we) ? word[we - 1 - b] : 1'b0;
            mb = (j >= d && b < we) ? mic[we - 1 - b] : 1'b1;
            do_bit(right, mb, lo, hi);
            got[SLOT_BITS - 1 - j]  = lo;
            expv[SLOT_BITS - 1 - j] = eb;
            if (lo !== hi) instab++;
        end
        check(instab == 0, "R1 output moved while bit clock high", 64'(instab), 64'd0);
        check(got === expv, $sformatf("%s/R6 tx slot d=%0d code=%0d right=%0d", req, d, code, right),
              64'(got), 64'(expv));
        check(hs_cnt - hs0 == (tx_on ? 1 : 0), "R7 one playback word per slot start",
              64'(hs_cnt - hs0), 64'(tx_on ? 1 : 0));
        check(ur_cnt - ur0 == (tx_on ? 0 : 1), "R8 underrun pulse cycles",
              64'(ur_cnt - ur0), 64'(tx_on ? 0 : 1));
        if (chk_rx) begin
            check(rx_cnt == rx_seen + 1 && rx_last == (mic & wmask(we)) && rx_last_right == right,
                  $sformatf("R9 capture d=%0d code=%0d right=%0d", d, code, right),
                  {31'(rx_cnt - rx_seen), rx_last_right, rx_last},
                  {31'd1, right, mic & wmask(we)});
            rx_seen = rx_cnt;
        end
    endtask

    task automatic run_frame(input int d, input int code, input logic [31:0] mic, input string req);
        run_slot(1'b0, d, code, 1'b1, mic, 1'b1, req);
        run_slot(1'b1, d, code, 1'b1, mic, 1'b1, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sd_o == 1'b0 && tx_ready == 1'b0 && tx_underrun == 1'b0 && rx_valid == 1'b0,
              "R3 reset outputs idle", {60'd0, sd_o, tx_ready, tx_underrun, rx_valid}, 64'd0);

        // R3: defaults before any write: delay 1, 32-bit samples
        preroll();
        run_frame(1, 0, 32'hC0DE_1234, "R3");

        // R4 and R5: sweep every width code at the default delay, written through R11
        for (int code = 0; code < 32; code++) begin
            write_cfg(1, code);
            preroll();
            run_frame(1, code, pat(1000 + code),
                      code == 0 ? "R11/R4" : (code >= 16 ? "R5" : "R4"));
        end

        // R2: sweep delays with full-width and narrow samples
        for (int d = 0; d < 8; d++) begin
            write_cfg(d, 0);
            preroll();
            run_frame(d, 0, pat(2000 + d), "R2");
            write_cfg(d, 9);
            preroll();
            run_frame(d, 9, pat(3000 + d), "R2");
        end

        // R8: left slot finds no word, right slot gets the next one
        write_cfg(2, 12);
        preroll();
        run_slot(1'b0, 2, 12, 1'b0, 32'h0000_0ABC, 1'b1, "R8");
        run_slot(1'b1, 2, 12, 1'b1, 32'h0000_0ABC, 1'b1, "R8");

        // R10: hold capture output, newer word replaces older
        rx_ready = 1'b0;
        preroll();
        run_slot(1'b0, 2, 12, 1'b1, 32'h0000_0111, 1'b0, "R10");
        run_slot(1'b1, 2, 12, 1'b1, 32'h0000_0E22, 1'b0, "R10");
        check(rx_valid == 1'b1 && rx_data == 32'h0000_0E22 && rx_right == 1'b1,
              "R10 newest word pending", {31'd0, rx_valid, rx_right, rx_data}, {31'd0, 1'b1, 1'b1, 32'h0000_0E22});
        repeat (6) @(negedge clk);
        check(rx_valid == 1'b1 && rx_data == 32'h0000_0E22, "R10 pending word held",
              {31'd0, rx_valid, rx_data}, {31'd0, 1'b1, 32'h0000_0E22});
        rx_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(rx_valid == 1'b0, "R10 word released after accept", 64'(rx_valid), 64'd0);
        rx_seen = rx_cnt;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule